// File: doc/BRIEF.md
# Prescaled PWM Generator with Full-Range Duty

This block drives a single pulse-width-modulated pin. A period counter of `RES` bits runs through all its values and wraps. It moves forward one step only when a prescale timer signals. The timer runs on the system clock. It counts up to a programmable limit, emits a one-cycle step pulse, and starts again from zero. The limit therefore sets the switching frequency: one PWM period lasts `(tmr_final + 1) * 2^RES` system clocks. With no prescaling (`tmr_final = 0`) and `RES = 8`, a 100 MHz clock gives a period of 256 clocks, which is about 390 kHz.

The duty word is one bit wider than the period counter. This lets the full range from 0% to 100% be reached: 0 keeps the pin low, and any value of `2^RES` or more keeps it high. A comparator decides the level and a flip-flop registers it, so the pin never carries a combinational glitch.

The duty word and the timer limit are plain control levels. They take effect on the next clock. They carry no valid/ready handshake, because the block never refuses or buffers a value, so back-pressure never arises. The reset is synchronous and active high.

Top module: `pwm_prescaled`

## Requirements
- R1: While `rst` is high at a clock edge, `pwm_out` is 0 after that edge. The timer and the period counter restart from zero.
- R2: A `duty` of 0 keeps `pwm_out` low in every cycle of the period.
- R3: Any `duty` value with bit `RES` set (value `2^RES` or more, e.g. 256 and 511 for `RES = 8`) keeps `pwm_out` high in every cycle. This gives exactly 100% duty.
- R4: Over one full period, `pwm_out` is high for exactly `duty * (tmr_final + 1)` clocks when `duty` is at most `2^RES`. A duty of `2^RES - 1` is therefore not 100%.
- R5: The PWM period is `(tmr_final + 1) * 2^RES` system clocks. The timer step pulse is a single cycle whenever `tmr_final` is non-zero.
- R6: The period counter changes only in a cycle that carries a timer step, and then it increments by one, wrapping from `2^RES - 1` to 0. After reset, the counter value seen at clock `n` (the n-th edge after release, counting from 1) is `floor((n-1)/(tmr_final+1)) mod 2^RES`.
- R7: The output is registered. A change of `duty` shows on `pwm_out` after the next clock edge, not before it.
- R8: After each clock edge, `pwm_out` equals the result of (counter value before the edge) < `duty`. The comparison is unsigned and `RES+1` bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| duty | input | RES+1 | Duty word: number of counter steps per period with the pin high |
| tmr_final | input | TMR_W | Timer limit; the counter steps once every tmr_final+1 clocks |
| pwm_out | output | 1 | Registered PWM output |

## Verification
A timer that ticks at the wrong moment shifts every later edge of `pwm_out`. The first high-to-low transition lands a multiple of `tmr_final+1` clocks early or late, and this is visible within the first period after reset. A period counter that skips or repeats a value changes the high time of the pin in the period where it happens. A comparator that is off by one shows up at the duty extremes as a single stray cycle per period. Because the output is registered, any such fault reaches the pin exactly one clock after the internal state goes wrong.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;
  localparam int unsigned DEF_RES   = 8;
  localparam int unsigned DEF_TMR_W = 8;
endpackage

// File: rtl/pwm_tick_timer.sv
module pwm_tick_timer #(
  parameter int unsigned TMR_W = pwm_gen_pkg::DEF_TMR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TMR_W-1:0] final_val,
  output logic             tick_o
);
  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  logic [TMR_W-1:0] cnt_q;

  // Compare with >= so that lowering the limit below the current count
  // recovers on the next cycle instead of waiting for a full wrap.
  assign tick_o = (cnt_q >= final_val);

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + ONE;
  end
endmodule

// File: rtl/pwm_step_counter.sv
module pwm_step_counter #(
  parameter int unsigned RES = pwm_gen_pkg::DEF_RES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           step_i,
  output logic [RES-1:0] count_o
);
  localparam logic [RES-1:0] ONE = RES'(1);

  always_ff @(posedge clk) begin
    if (rst)         count_o <= '0;
    else if (step_i) count_o <= count_o + ONE;
  end
endmodule

// File: rtl/pwm_level_reg.sv
module pwm_level_reg #(
  parameter int unsigned RES = pwm_gen_pkg::DEF_RES
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [RES-1:0] count_i,
  input  logic [RES:0]   duty_i,
  output logic           pwm_o
);
  logic level_d;

  assign level_d = ({1'b0, count_i} < duty_i);

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= level_d;
  end
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled #(
  parameter int unsigned RES   = pwm_gen_pkg::DEF_RES,
  parameter int unsigned TMR_W = pwm_gen_pkg::DEF_TMR_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RES:0]     duty,
  input  logic [TMR_W-1:0] tmr_final,
  output logic             pwm_out
);
  logic           tmr_tick;
  logic [RES-1:0] step_cnt;

  pwm_tick_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .final_val (tmr_final),
    .tick_o    (tmr_tick)
  );

  pwm_step_counter #(.RES(RES)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .step_i  (tmr_tick),
    .count_o (step_cnt)
  );

  pwm_level_reg #(.RES(RES)) u_level (
    .clk     (clk),
    .rst     (rst),
    .count_i (step_cnt),
    .duty_i  (duty),
    .pwm_o   (pwm_out)
  );
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk #(
  parameter int unsigned RES   = pwm_gen_pkg::DEF_RES,
  parameter int unsigned TMR_W = pwm_gen_pkg::DEF_TMR_W
) (
  input logic             clk,
  input logic             rst,
  input logic [RES:0]     duty,
  input logic [TMR_W-1:0] tmr_final,
  input logic             pwm_out,
  input logic [RES-1:0]   cnt,
  input logic             tick
);
  localparam logic [RES-1:0] ONE = RES'(1);

  p_reset_low_r1: assert property (@(posedge clk) rst |=> !pwm_out)
    else $error("R1 output high after reset edge");

  p_zero_duty_r2: assert property (@(posedge clk) disable iff (rst)
    (duty == '0) |=> !pwm_out)
    else $error("R2 output high with zero duty");

  p_full_duty_r3: assert property (@(posedge clk) disable iff (rst)
    duty[RES] |=> pwm_out)
    else $error("R3 output low with full duty");

  p_tick_single_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && tmr_final != '0) |=> (!tick || tmr_final == '0))
    else $error("R5 timer step longer than one cycle");

  p_hold_no_tick_r6: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt))
    else $error("R6 counter moved without a step");

  p_step_on_tick_r6: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt == $past(cnt) + ONE))
    else $error("R6 counter did not advance on a step");

  p_level_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pwm_out == ({1'b0, $past(cnt)} < $past(duty))))
    else $error("R8 output level disagrees with comparison");
endmodule

bind pwm_prescaled pwm_prescaled_chk #(.RES(RES), .TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .duty      (duty),
  .tmr_final (tmr_final),
  .pwm_out   (pwm_out),
  .cnt       (step_cnt),
  .tick      (tmr_tick)
);

// File: tb/pwm_prescaled_bench.sv
module pwm_prescaled_bench;
  localparam int RES   = 8;
  localparam int TMR_W = 8;
  localparam int FULL  = 1 << RES;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [RES:0]     duty = '0;
  logic [TMR_W-1:0] tfin = '0;
  logic             pwm;

  int n, checks, fails, highs, last_rise, period_seen;
  bit prev;

  always #5 clk = ~clk;

  pwm_prescaled #(.RES(RES), .TMR_W(TMR_W)) u_pwm_prescaled (
    .clk(clk), .rst(rst), .duty(duty), .tmr_final(tfin), .pwm_out(pwm)
  );

  function automatic bit model(int cyc, int f, int d);
    int c;
    c = ((cyc - 1) / (f + 1)) % FULL;
    return c < d;
  endfunction

  task automatic check(bit act, bit exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d actual %0b expected %0b", tag, n, act, exp);
    end
  endtask

  task automatic check_int(int act, int exp, string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(int f);
    rst  = 1'b1;
    tfin = TMR_W'(f);
    repeat (3) begin
      @(posedge clk); #2;
      check(pwm, 1'b0, "R1 reset");
    end
    rst = 1'b0;
    n = 0; prev = 1'b0; highs = 0; last_rise = -1; period_seen = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk); #2;
    n++;
    check(pwm, model(n, int'(tfin), int'(duty)), tag);
    if (pwm) highs++;
    if (pwm && !prev) begin
      if (last_rise >= 0) period_seen = n - last_rise;
      last_rise = n;
    end
    prev = pwm;
  endtask

  initial begin
    #(10 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual running expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));

    // R2: zero duty stays low
    duty = '0; do_reset(0);
    for (int i = 0; i < 300; i++) step("R2 zero duty");
    check_int(highs, 0, "R2 high count");

    // R3: full duty stays high, also with upper values
    duty = 9'd256; do_reset(1);
    for (int i = 0; i < 600; i++) step("R3 full duty");
    check_int(highs, 600, "R3 high count 256");
    duty = 9'd511; do_reset(0);
    for (int i = 0; i < 300; i++) step("R3 full duty 511");
    check_int(highs, 300, "R3 high count 511");

    // R4: exact high time per period
    duty = 9'd100; do_reset(0);
    for (int i = 0; i < FULL; i++) step("R4 duty 100");
    check_int(highs, 100, "R4 high count 100");
    duty = 9'd255; do_reset(0);
    for (int i = 0; i < FULL; i++) step("R4 duty 255");
    check_int(highs, 255, "R4 high count 255 not full");
    duty = 9'd2; do_reset(3);
    for (int i = 0; i < 4 * FULL; i++) step("R6 prescaled steps");
    check_int(highs, 8, "R6 high count prescale 4");

    // R5: period length with prescaling
    duty = 9'd1; do_reset(2);
    for (int i = 0; i < 3 * FULL + 10; i++) step("R5 period");
    check_int(period_seen, 3 * FULL, "R5 period length");

    // R7 and R8: duty change appears after the next edge
    duty = '0; do_reset(3);
    for (int i = 0; i < 5; i++) step("R8 pre change");
    check(pwm, 1'b0, "R7 low before change");
    duty = 9'd256;
    check(pwm, 1'b0, "R7 no combinational path");
    step("R7 after change");
    check(pwm, 1'b1, "R7 high one edge later");

    // R1: first registered comparison after reset
    duty = 9'd5; do_reset(0);
    step("R1 first cycle");
    check(pwm, 1'b1, "R1 first compare high");

    // R8: random duty and prescale
    for (int seg = 0; seg < 8; seg++) begin
      int left;
      duty = 9'($urandom % 300);
      do_reset(int'($urandom % 4));
      left = 0;
      for (int i = 0; i < 1500; i++) begin
        if (left == 0) begin
          case ($urandom % 6)
            0: duty = '0;
            1: duty = 9'd256;
            2: duty = 9'd255;
            default: duty = 9'($urandom % 300);
          endcase
          left = int'($urandom % 200) + 1;
        end
        left--;
        step("R8 random");
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule